// File: doc/BRIEF.md
# Fast Ethernet 4B/5B Receive Decoder

This block sits between symbol alignment and the MAC on the 100 Mb/s receive path. Once per strobe it takes a 5-bit code group and produces one nibble of the MAC receive interface: a data nibble, a data-valid flag and an error flag. It finds the two-symbol start delimiter and hands it on as two preamble nibbles. It then converts data symbols to nibbles until it sees the two-symbol end delimiter. A return to idle inside a frame also ends it.

To tell a real delimiter pair from a lone first half, the decoder looks one code group ahead. The output for a code group is therefore registered on the strobe that brings the next code group. Symbols that are not valid data, or the halt symbol, inside a frame are passed on as errored nibbles. Idle inside a frame closes the frame and raises a one-nibble error pulse.

Top module: `rx4b5b_decoder`

## Requirements
- R1: While reset is asserted and until the first strobe after its release, `rx_dv`, `rx_er` and `rx_nib` are all 0.
- R2: Inside a frame, the data symbols map to nibbles as follows: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F. Each is output with `rx_dv`=1 and `rx_er`=0.
- R3: A symbol 11000 directly followed by 10001 starts a frame. Each of the two symbols is output as nibble 0101 with `rx_dv`=1 and `rx_er`=0, and `rx_dv` rises on the first of them.
- R4: A 11000 that is not directly followed by 10001 starts nothing, and its slot is output as `rx_dv`=0.
- R5: A symbol 01101 directly followed by 00111 ends a frame. The output slot of the 01101 already carries `rx_dv`=0 and `rx_er`=0.
- R6: Inside a frame, any symbol that is neither data nor part of an end pair is output as `rx_dv`=1, `rx_er`=1, nibble 0000. This covers the invalid symbols 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000 and 11001, the halt symbol 00100, and a stray delimiter half. The frame continues afterwards.
- R7: Idle 11111 inside a frame ends it. Its slot is output as `rx_dv`=0, `rx_er`=1, nibble 0000, and `rx_er` is 0 again on the next slot.
- R8: Outside a frame, every symbol except a start pair gives `rx_dv`=0, `rx_er`=0, nibble 0000. This includes invalid and halt symbols.
- R9: The output for the code group taken on strobe n is registered on strobe n+1. While `cg_vld` is 0 the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz receive symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cg_vld | input | 1 | Strobe: `cg_in` holds a new aligned code group |
| cg_in | input | 5 | Aligned 5-bit code group |
| rx_nib | output | 4 | Receive nibble to the MAC |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |

## Verification
The hardest situations to reach are a delimiter half that appears on its own. A 11000 before a non-10001 symbol, a doubled 11000 ahead of a genuine start, and a 01101 inside a frame that is not followed by 00111 all have to be rejected, using only one symbol of lookahead. The stimulus builds these exact symbol sequences on purpose. It also places strobe gaps inside frames, so the lookahead register is known to hold across idle cycles. A reference model in the bench, written from the requirements, predicts every output slot.

// File: rtl/rx4b5b_pkg.sv
package rx4b5b_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  localparam logic [CG_W-1:0] CG_IDLE  = 5'b11111;
  localparam logic [CG_W-1:0] CG_SSD_A = 5'b11000;
  localparam logic [CG_W-1:0] CG_SSD_B = 5'b10001;
  localparam logic [CG_W-1:0] CG_ESD_A = 5'b01101;
  localparam logic [CG_W-1:0] CG_ESD_B = 5'b00111;
  localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;

  typedef enum logic [2:0] {
    K_DATA, K_SSD_A, K_SSD_B, K_ESD_A, K_ESD_B, K_IDLE, K_BAD
  } cg_kind_e;

  typedef struct packed {
    cg_kind_e          kind;
    logic [NIB_W-1:0]  nib;
  } cg_info_t;

  typedef enum logic [1:0] {
    S_IDLE, S_PRE2, S_BODY
  } frm_st_e;
endpackage

// File: rtl/rx4b5b_cgreg.sv
module rx4b5b_cgreg
  import rx4b5b_pkg::*;
#(
  parameter int W = CG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= {W{1'b1}};
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/rx4b5b_classify.sv
module rx4b5b_classify
  import rx4b5b_pkg::*;
(
  input  logic [CG_W-1:0] code,
  output cg_info_t        info
);
  always_comb begin
    info.kind = K_DATA;
    info.nib  = '0;
    unique case (code)
      5'b11110: info.nib = 4'h0;
      5'b01001: info.nib = 4'h1;
      5'b10100: info.nib = 4'h2;
      5'b10101: info.nib = 4'h3;
      5'b01010: info.nib = 4'h4;
      5'b01011: info.nib = 4'h5;
      5'b01110: info.nib = 4'h6;
      5'b01111: info.nib = 4'h7;
      5'b10010: info.nib = 4'h8;
      5'b10011: info.nib = 4'h9;
      5'b10110: info.nib = 4'hA;
      5'b10111: info.nib = 4'hB;
      5'b11010: info.nib = 4'hC;
      5'b11011: info.nib = 4'hD;
      5'b11100: info.nib = 4'hE;
      5'b11101: info.nib = 4'hF;
      CG_SSD_A: info.kind = K_SSD_A;
      CG_SSD_B: info.kind = K_SSD_B;
      CG_ESD_A: info.kind = K_ESD_A;
      CG_ESD_B: info.kind = K_ESD_B;
      CG_IDLE:  info.kind = K_IDLE;
      default:  info.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/rx4b5b_frame_fsm.sv
module rx4b5b_frame_fsm
  import rx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  cg_info_t         cur,
  input  cg_info_t         nxt,
  output logic [NIB_W-1:0] rx_nib,
  output logic             rx_dv,
  output logic             rx_er
);
  frm_st_e          st_q, st_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic             dv_q, dv_d, er_q, er_d;

  always_comb begin
    st_d  = st_q;
    nib_d = nib_q;
    dv_d  = dv_q;
    er_d  = er_q;
    if (en) begin
      nib_d = '0;
      dv_d  = 1'b0;
      er_d  = 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (cur.kind == K_SSD_A && nxt.kind == K_SSD_B) begin
            st_d  = S_PRE2;
            dv_d  = 1'b1;
            nib_d = NIB_PRE;
          end
        end
        S_PRE2: begin
          st_d  = S_BODY;
          dv_d  = 1'b1;
          nib_d = NIB_PRE;
        end
        default: begin
          if (cur.kind == K_ESD_A && nxt.kind == K_ESD_B) begin
            st_d = S_IDLE;
          end else if (cur.kind == K_IDLE) begin
            st_d = S_IDLE;
            er_d = 1'b1;
          end else if (cur.kind == K_DATA) begin
            dv_d  = 1'b1;
            nib_d = cur.nib;
          end else begin
            dv_d = 1'b1;
            er_d = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      nib_q <= '0;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      nib_q <= nib_d;
      dv_q  <= dv_d;
      er_q  <= er_d;
    end
  end

  assign rx_nib = nib_q;
  assign rx_dv  = dv_q;
  assign rx_er  = er_q;

  p_dv_rise_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (rx_nib == NIB_PRE && !rx_er));
  p_second_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PRE2) |-> (rx_dv && rx_nib == NIB_PRE));
  p_quiet_nib_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> (rx_nib == '0));
  p_er_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_er && !rx_dv) |=> !rx_er);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({rx_dv, rx_er, rx_nib}));
endmodule

// File: rtl/rx4b5b_decoder.sv
module rx4b5b_decoder
  import rx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cg_vld,
  input  logic [CG_W-1:0]  cg_in,
  output logic [NIB_W-1:0] rx_nib,
  output logic             rx_dv,
  output logic             rx_er
);
  localparam int N_VIEW = 2;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [CG_W-1:0] held_cg;
  logic [N_VIEW-1:0][CG_W-1:0] view_cg;
  cg_info_t [N_VIEW-1:0] view_info;

  rx4b5b_cgreg #(.W(CG_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (cg_vld),
    .d     (cg_in),
    .q     (held_cg)
  );

  assign view_cg[0] = held_cg;
  assign view_cg[1] = cg_in;

  for (genvar gi = 0; gi < N_VIEW; gi++) begin : g_cls
    rx4b5b_classify u_cls (
      .code (view_cg[gi]),
      .info (view_info[gi])
    );
  end

  rx4b5b_frame_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (cg_vld),
    .cur    (view_info[0]),
    .nxt    (view_info[1]),
    .rx_nib (rx_nib),
    .rx_dv  (rx_dv),
    .rx_er  (rx_er)
  );
endmodule

// File: tb/rx4b5b_decoder_tb.sv
module rx4b5b_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cg_vld = 1'b0;
  logic [4:0] cg_in = 5'b11111;
  logic [3:0] rx_nib;
  logic       rx_dv, rx_er;

  int checks = 0;
  int errors = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];
  logic [5:0] last_exp = 6'b0;
  string      idle_tag = "R8";

  int         m_state = 0;
  logic [4:0] m_prev = 5'b11111;

  always #5 clk = ~clk;

  rx4b5b_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cg_vld(cg_vld), .cg_in(cg_in),
    .rx_nib(rx_nib), .rx_dv(rx_dv), .rx_er(rx_er)
  );

  function automatic logic [4:0] enc(input int n);
    case (n)
      0: enc = 5'b11110;  1: enc = 5'b01001;  2: enc = 5'b10100;  3: enc = 5'b10101;
      4: enc = 5'b01010;  5: enc = 5'b01011;  6: enc = 5'b01110;  7: enc = 5'b01111;
      8: enc = 5'b10010;  9: enc = 5'b10011; 10: enc = 5'b10110; 11: enc = 5'b10111;
      12: enc = 5'b11010; 13: enc = 5'b11011; 14: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  function automatic int dec(input logic [4:0] c);
    dec = -1;
    for (int i = 0; i < 16; i++) if (enc(i) == c) dec = i;
  endfunction

  task automatic push(input logic dv, input logic er, input logic [3:0] nb, input string t);
    exp_q.push_back({dv, er, nb});
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [4:0] c);
    case (m_state)
      0: if (m_prev == 5'b11000 && c == 5'b10001) begin
           push(1, 0, 4'h5, "R3"); m_state = 1;
         end else push(0, 0, 4'h0, idle_tag);
      1: begin push(1, 0, 4'h5, "R3"); m_state = 2; end
      default:
        if (m_prev == 5'b01101 && c == 5'b00111) begin
          push(0, 0, 4'h0, "R5"); m_state = 0;
        end else if (m_prev == 5'b11111) begin
          push(0, 1, 4'h0, "R7"); m_state = 0;
        end else if (dec(m_prev) >= 0) push(1, 0, 4'(dec(m_prev)), "R2");
        else push(1, 1, 4'h0, "R6");
    endcase
    m_prev = c;
    @(negedge clk);
    cg_vld = 1'b1;
    cg_in  = c;
    @(negedge clk);
    cg_vld = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      if (cg_vld) begin
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected output slot act=%b exp=none", {rx_dv, rx_er, rx_nib});
        end else begin
          logic [5:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if ({rx_dv, rx_er, rx_nib} !== e) begin
            errors++;
            $display("FAIL %s act dv/er/nib=%b exp=%b", t, {rx_dv, rx_er, rx_nib}, e);
          end
          last_exp = e;
        end
      end else begin
        checks++;
        if ({rx_dv, rx_er, rx_nib} !== last_exp) begin
          errors++;
          $display("FAIL R9 hold act=%b exp=%b", {rx_dv, rx_er, rx_nib}, last_exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] bad[11];
    bad = '{5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00101, 5'b00110,
            5'b01000, 5'b01100, 5'b10000, 5'b11001, 5'b00100};
    repeat (3) @(negedge clk);
    checks++;
    if ({rx_dv, rx_er, rx_nib} !== 6'b0) begin
      errors++;
      $display("FAIL R1 reset act=%b exp=000000", {rx_dv, rx_er, rx_nib});
    end
    rst_n = 1'b1;
    gap(5);
    // R1 idle after reset, R2/R3/R5 full frame
    repeat (4) send(5'b11111);
    send(5'b11000); send(5'b10001);
    for (int i = 0; i < 16; i++) send(enc(i));
    send(5'b01101); send(5'b00111);
    repeat (3) send(5'b11111);
    // R4 lone start halves
    idle_tag = "R4";
    send(5'b11000); send(5'b11111); send(5'b11000); send(enc(3));
    send(5'b11000); send(5'b11000); send(5'b10001);
    send(enc(9)); send(5'b01101); send(5'b00111);
    send(5'b11111);
    // R8 junk outside frame
    idle_tag = "R8";
    for (int i = 0; i < 11; i++) send(bad[i]);
    send(5'b01101); send(5'b00111); send(5'b10001); send(enc(6));
    send(5'b11111); send(5'b11111);
    // R6 errored symbols inside frame, with R9 gaps
    send(5'b11000); send(5'b10001);
    for (int i = 0; i < 11; i++) begin
      send(bad[i]);
      send(enc(i));
      if (i == 4) gap(3);
    end
    send(5'b01101); send(enc(7)); send(5'b00111); send(5'b11000);
    send(enc(2)); send(5'b01101); gap(2); send(5'b00111);
    send(5'b11111); send(5'b11111);
    // R7 premature idle
    send(5'b11000); send(5'b10001); send(enc(1)); send(enc(2));
    send(5'b11111); send(5'b11111); send(5'b11111);
    send(5'b11000); send(5'b10001); send(enc(12)); send(5'b01101);
    send(5'b11111); send(5'b11111);
    gap(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 pending act=%0d exp=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule